// File: doc/BRIEF.md
# Double-Precision Rounding and Result Packing Stage

This block is the last stage of a fused multiply-add datapath. It takes an already normalised result (sign, biased 11-bit exponent, 52 fraction bits kept after truncation, and the guard, round and sticky bits below them). It applies one of four rounding policies and folds any carry that runs off the top of the fraction into the exponent. It then packs the outcome into a 64-bit IEEE 754 double-precision word.

The stage also merges the exception flags raised by the earlier stages with its own overflow indication into one registered flag word. An active-low quiet bit in the control byte can hide the invalid-class flags. Each accepted operation produces a single-cycle completion strobe alongside the registered result.

Top module: `rndpk_top`

## Requirements
- R1: The result and flags are registered. `done` is high for exactly the one cycle after each cycle in which `in_valid` was high, and low in every other cycle, including back-to-back operations and during reset.
- R2: With control bits [7:6] = 00 (nearest, ties away from zero), the fraction is incremented exactly when the guard bit is 1.
- R3: With control bits [7:6] = 01 (nearest, ties to even), the fraction is incremented exactly when guard is 1 and at least one of round, sticky or fraction bit 0 is 1.
- R4: With control bits [7:6] = 10 (toward +infinity), the fraction is incremented exactly when the sign is 0 and at least one of guard, round or sticky is 1.
- R5: With control bits [7:6] = 11 (truncate), the fraction and exponent pass through unchanged whatever guard, round and sticky are.
- R6: When the increment carries out of a fraction of all ones, the fraction becomes zero and the exponent rises by one.
- R7: When that carry brings the exponent to 0x7FF, flag bit 3 (overflow) is set and the result is infinity of the input sign (fraction zero).
- R8: The output word holds the sign in bit 63, the exponent in bits 62..52 and the fraction in bits 51..0.
- R9: The output flags equal the incoming stage flags, with bit 3 (overflow) also set by R7. The flag layout is bit 0 NaN operand, bit 1 infinite operand, bit 2 invalid operation, bit 3 overflow, bit 4 underflow, bit 5 subnormal operand.
- R10: When control bit 5 (quiet, active low) is 0, output flag bits 0 and 2 read 0. The other bits are not affected.
- R11: In cycles where `in_valid` is low, the registered result and flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on the field inputs are to be rounded this cycle |
| in_ctrl | input | 8 | Control byte: [7:6] rounding policy, [5] quiet (active low), rest unused |
| in_sign | input | 1 | Sign of the normalised result |
| in_exp | input | 11 | Biased exponent of the normalised result, below 0x7FF |
| in_frac | input | 52 | Fraction truncated to 52 bits |
| in_guard | input | 1 | First bit below the fraction |
| in_round | input | 1 | Second bit below the fraction |
| in_sticky | input | 1 | OR of all remaining lower bits |
| in_flags | input | 6 | Flags raised by earlier stages |
| res_o | output | 64 | Packed double-precision result |
| flags_o | output | 6 | Merged and masked flag word |
| done | output | 1 | Completion strobe, one cycle per operation |

## Verification
The overflow that comes from a rounding carry and the quiet-bit masking of incoming invalid flags can act on the same flag word in the same cycle. The bench provokes this with an all-ones fraction at exponent 0x7FE, guard set, an incoming invalid and NaN flag, and the quiet bit low. The expected word is infinity with bit 3 set and bits 0 and 2 cleared, while untouched flags such as bit 4 pass through. The bench also runs the same carry with the quiet bit high, where all three flags must appear together.

// File: rtl/rndpk_pkg.sv
// Shared constants and types for the rounding/packing stage.
// Assumes IEEE 754 double layout unless parameters are overridden.
package rndpk_pkg;

    localparam int EXP_W_D  = 11;
    localparam int FRAC_W_D = 52;
    localparam int FLAG_W_D = 6;

    // Rounding policy encoding held in control bits [7:6]
    typedef enum logic [1:0] {
        RM_NEAR  = 2'b00,
        RM_EVEN  = 2'b01,
        RM_PINF  = 2'b10,
        RM_TRUNC = 2'b11
    } rmode_e;

    // Control byte field positions
    localparam int CTL_MODE_LO  = 6;
    localparam int CTL_QUIET_N  = 5;

    // Flag bit positions
    localparam int FL_NAN = 0;
    localparam int FL_INF = 1;
    localparam int FL_INV = 2;
    localparam int FL_OVF = 3;
    localparam int FL_UNF = 4;
    localparam int FL_DEN = 5;

    // True for flags that the quiet control hides
    function automatic logic is_invalid_class(input int idx);
        return (idx == FL_NAN) || (idx == FL_INV);
    endfunction

endpackage

// File: rtl/rndpk_decide.sv
// Decides whether the truncated fraction must be bumped by one ulp.
// Assumes guard/round/sticky already reflect the discarded bits.
module rndpk_decide
    import rndpk_pkg::*;
(
    input  rmode_e mode,
    input  logic   sign,
    input  logic   lsb,
    input  logic   guard,
    input  logic   rnd,
    input  logic   sticky,
    output logic   inc
);

    // Per-policy increment selection (R2..R5)
    always_comb begin
        unique case (mode)
            RM_NEAR:  inc = guard;
            RM_EVEN:  inc = guard & (rnd | sticky | lsb);
            RM_PINF:  inc = ~sign & (guard | rnd | sticky);
            RM_TRUNC: inc = 1'b0;
            default:  inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/rndpk_incr.sv
// Adds the rounding increment, folds fraction carry into the exponent
// and saturates to infinity when the exponent reaches all ones.
// Assumes the incoming exponent is below the all-ones code.
module rndpk_incr #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              inc,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              ovf
);

    localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

    logic [FRAC_W:0]  sum;
    logic [EXP_W-1:0] exp_bump;

    // Fraction increment with carry bit on top
    always_comb sum = {1'b0, frac_i} + {{FRAC_W{1'b0}}, inc};

    // Exponent after a possible carry (R6)
    always_comb exp_bump = sum[FRAC_W] ? exp_i + 1'b1 : exp_i;

    // Carry handling and overflow to infinity (R6, R7)
    always_comb begin
        exp_o  = exp_bump;
        frac_o = sum[FRAC_W-1:0];
        ovf    = 1'b0;
        if (sum[FRAC_W] && exp_bump == EXP_MAX) begin
            ovf    = 1'b1;
            frac_o = '0;
        end
    end

endmodule

// File: rtl/rndpk_flags.sv
// Merges stage flags with the rounding overflow and applies quiet masking.
// Assumes the package flag positions.
module rndpk_flags
    import rndpk_pkg::*;
#(
    parameter int FLAG_W = 6
) (
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              quiet_n,
    input  logic              ovf,
    output logic [FLAG_W-1:0] flags_o
);

    // One cell per flag bit: mask, merge or pass (R9, R10)
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (is_invalid_class(i)) begin : g_mask
            assign flags_o[i] = flags_i[i] & quiet_n;
        end else if (i == FL_OVF) begin : g_ovf
            assign flags_o[i] = flags_i[i] | ovf;
        end else begin : g_pass
            assign flags_o[i] = flags_i[i];
        end
    end

endmodule

// File: rtl/rndpk_top.sv
// Final rounding and packing stage of a fused multiply-add pipeline.
// Registers the packed result and merged flags one cycle after in_valid.
// Assumes inputs are normalised and the exponent is below all ones.
module rndpk_top
    import rndpk_pkg::*;
#(
    parameter int EXP_W  = EXP_W_D,
    parameter int FRAC_W = FRAC_W_D,
    parameter int FLAG_W = FLAG_W_D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [7:0]                in_ctrl,
    input  logic                      in_sign,
    input  logic [EXP_W-1:0]          in_exp,
    input  logic [FRAC_W-1:0]         in_frac,
    input  logic                      in_guard,
    input  logic                      in_round,
    input  logic                      in_sticky,
    input  logic [FLAG_W-1:0]         in_flags,
    output logic [EXP_W+FRAC_W:0]     res_o,
    output logic [FLAG_W-1:0]         flags_o,
    output logic                      done
);

    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    rmode_e            mode;
    logic              inc;
    logic              ovf;
    logic [EXP_W-1:0]  exp_r;
    logic [FRAC_W-1:0] frac_r;
    logic [FLAG_W-1:0] flags_n;
    logic [WORD_W-1:0] word_n;

    // Decode the rounding policy field
    always_comb mode = rmode_e'(in_ctrl[CTL_MODE_LO +: 2]);

    rndpk_decide u_decide (
        .mode   (mode),
        .sign   (in_sign),
        .lsb    (in_frac[0]),
        .guard  (in_guard),
        .rnd    (in_round),
        .sticky (in_sticky),
        .inc    (inc)
    );

    rndpk_incr #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_incr (
        .exp_i  (in_exp),
        .frac_i (in_frac),
        .inc    (inc),
        .exp_o  (exp_r),
        .frac_o (frac_r),
        .ovf    (ovf)
    );

    rndpk_flags #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .flags_i (in_flags),
        .quiet_n (in_ctrl[CTL_QUIET_N]),
        .ovf     (ovf),
        .flags_o (flags_n)
    );

    // Pack sign, exponent, fraction into one word (R8)
    always_comb word_n = {in_sign, exp_r, frac_r};

    // Output registers: load on valid, hold otherwise (R1, R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            flags_o <= '0;
            done    <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                res_o   <= word_n;
                flags_o <= flags_n;
            end
        end
    end

endmodule

// File: rtl/rndpk_chk.sv
// Property checker for rndpk_top, attached by bind below.
module rndpk_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int FLAG_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [7:0]            in_ctrl,
    input logic                  in_sign,
    input logic [EXP_W-1:0]      in_exp,
    input logic [FRAC_W-1:0]     in_frac,
    input logic [EXP_W+FRAC_W:0] res_o,
    input logic [FLAG_W-1:0]     flags_o,
    input logic                  done
);

    a_r1_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    a_r5_truncate_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(in_ctrl[7:6]) == 2'b11)
        |-> res_o[EXP_W+FRAC_W-1:0] == {$past(in_exp), $past(in_frac)});

    a_r7_inf_has_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_o[EXP_W+FRAC_W-1:FRAC_W] == {EXP_W{1'b1}})
        |-> (flags_o[3] && res_o[FRAC_W-1:0] == '0));

    a_r8_sign_position: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_o[EXP_W+FRAC_W] == $past(in_sign));

    a_r10_quiet_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(in_ctrl[5])) |-> (!flags_o[0] && !flags_o[2]));

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_o) && $stable(flags_o)));

endmodule

bind rndpk_top rndpk_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ctrl  (in_ctrl),
    .in_sign  (in_sign),
    .in_exp   (in_exp),
    .in_frac  (in_frac),
    .res_o    (res_o),
    .flags_o  (flags_o),
    .done     (done)
);

// File: tb/rndpk_top_tb.sv
// Scoreboard bench: driver pushes expected words, monitor compares.
module rndpk_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_ctrl = '0;
    logic        in_sign = 1'b0;
    logic [10:0] in_exp = '0;
    logic [51:0] in_frac = '0;
    logic        in_guard = 1'b0;
    logic        in_round = 1'b0;
    logic        in_sticky = 1'b0;
    logic [5:0]  in_flags = '0;
    logic [63:0] res_o;
    logic [5:0]  flags_o;
    logic        done;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    logic [63:0] q_res[$];
    logic [5:0]  q_fl[$];
    string       q_tag[$];
    logic [63:0] last_res = '0;
    logic [5:0]  last_fl = '0;

    always #10 clk = ~clk;

    rndpk_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
        .in_guard(in_guard), .in_round(in_round), .in_sticky(in_sticky),
        .in_flags(in_flags), .res_o(res_o), .flags_o(flags_o), .done(done)
    );

    // Reference model written from the requirements
    task automatic drive(input string tag, input logic [1:0] md, input logic qn,
                         input logic s, input logic [10:0] e, input logic [51:0] f,
                         input logic g, input logic r, input logic st,
                         input logic [5:0] fl);
        logic bump;
        logic [52:0] fs;
        logic [10:0] ee;
        logic [51:0] ff;
        logic [5:0] fo;
        case (md)
            2'b00: bump = g;
            2'b01: bump = g && (r || st || f[0]);
            2'b10: bump = !s && (g || r || st);
            default: bump = 1'b0;
        endcase
        fs = {1'b0, f} + 53'(bump);
        ee = e; ff = fs[51:0]; fo = fl;
        if (fs[52]) begin
            ee = e + 11'd1;
            if (ee == 11'h7FF) begin ff = '0; fo[3] = 1'b1; end
        end
        if (!qn) begin fo[0] = 1'b0; fo[2] = 1'b0; end
        @(negedge clk);
        in_valid = 1'b1; in_ctrl = {md, qn, 5'b0}; in_sign = s; in_exp = e;
        in_frac = f; in_guard = g; in_round = r; in_sticky = st; in_flags = fl;
        q_res.push_back({s, ee, ff});
        q_fl.push_back(fo);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_guard = ~in_guard; in_frac = ~in_frac; in_flags = ~in_flags;
        end
    endtask

    // Monitor: a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            checks++;
            if (done !== (q_res.size() > 0)) begin
                failures++;
                $display("FAIL R1 done actual=%b expected=%b", done, q_res.size() > 0);
            end
            if (done && q_res.size() > 0) begin
                logic [63:0] er;
                logic [5:0]  ef;
                string t;
                er = q_res.pop_front(); ef = q_fl.pop_front(); t = q_tag.pop_front();
                checks += 2;
                if (res_o !== er) begin
                    failures++;
                    $display("FAIL %s result actual=%h expected=%h", t, res_o, er);
                end
                if (flags_o !== ef) begin
                    failures++;
                    $display("FAIL %s flags actual=%b expected=%b", t, flags_o, ef);
                end
                last_res = er; last_fl = ef;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (res_o !== 64'd0 || flags_o !== 6'd0 || done !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%h/%b/%b expected=0/0/0", res_o, flags_o, done);
        end
        @(negedge clk); rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 nearest, ties away
        drive("R2", 2'b00, 1, 0, 11'h400, 52'h5, 1, 0, 0, 6'h00);
        drive("R2", 2'b00, 1, 0, 11'h400, 52'h6, 0, 1, 1, 6'h00);
        drive("R2", 2'b00, 1, 1, 11'h3FF, 52'h8, 1, 0, 0, 6'h00);
        // R3 nearest even
        drive("R3", 2'b01, 1, 0, 11'h400, 52'h4, 1, 0, 0, 6'h00);
        drive("R3", 2'b01, 1, 0, 11'h400, 52'h5, 1, 0, 0, 6'h00);
        drive("R3", 2'b01, 1, 0, 11'h400, 52'h4, 1, 0, 1, 6'h00);
        drive("R3", 2'b01, 1, 0, 11'h400, 52'h5, 0, 1, 1, 6'h00);
        // R4 toward +inf
        drive("R4", 2'b10, 1, 0, 11'h200, 52'h10, 0, 0, 1, 6'h00);
        drive("R4", 2'b10, 1, 1, 11'h200, 52'h10, 1, 1, 1, 6'h00);
        // R5 truncate
        drive("R5", 2'b11, 1, 0, 11'h123, 52'hFFFFFFFFFFFFF, 1, 1, 1, 6'h00);
        idle(2);
        // R8 packing with a literal expectation
        drive("R8", 2'b11, 1, 1, 11'h3FF, 52'h123456789ABCD, 0, 0, 0, 6'h00);
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #6;
        checks++;
        if (res_o !== 64'hBFF123456789ABCD) begin
            failures++;
            $display("FAIL R8 actual=%h expected=%h", res_o, 64'hBFF123456789ABCD);
        end
        // R6 carry into exponent
        drive("R6", 2'b00, 1, 0, 11'h400, 52'hFFFFFFFFFFFFF, 1, 0, 0, 6'h00);
        drive("R6", 2'b10, 1, 0, 11'h001, 52'hFFFFFFFFFFFFF, 0, 0, 1, 6'h00);
        // R7 overflow to infinity, with R9 merge
        drive("R7", 2'b00, 1, 1, 11'h7FE, 52'hFFFFFFFFFFFFF, 1, 0, 0, 6'h05);
        drive("R7", 2'b01, 1, 0, 11'h7FE, 52'hFFFFFFFFFFFFF, 1, 1, 0, 6'h00);
        // R9 pass-through of stage flags
        drive("R9", 2'b11, 1, 0, 11'h300, 52'h1, 0, 0, 0, 6'h32);
        drive("R9", 2'b11, 1, 0, 11'h300, 52'h1, 0, 0, 0, 6'h3F);
        // R10 quiet low masks bits 0 and 2, also with overflow in same cycle
        drive("R10", 2'b11, 0, 0, 11'h300, 52'h1, 0, 0, 0, 6'h3F);
        drive("R10", 2'b00, 0, 0, 11'h7FE, 52'hFFFFFFFFFFFFF, 1, 0, 0, 6'h15);
        // R11 hold while idle under changing inputs
        idle(4);
        @(posedge clk); #6;
        checks++;
        if (res_o !== last_res || flags_o !== last_fl) begin
            failures++;
            $display("FAIL R11 actual=%h/%b expected=%h/%b", res_o, flags_o, last_res, last_fl);
        end
        idle(2);
        checks++;
        if (q_res.size() != 0) begin
            failures++;
            $display("FAIL R1 pending actual=%0d expected=0", q_res.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule